// File: doc/BRIEF.md
# Burst Segmenter with Control Insertion

This block sits on the transmit data path of one channel. It cuts packet data into bursts and opens a slot for a control word at every burst boundary. Data arrives as words of `WORD_BYTES` bytes (16 or 32) with start- and end-of-packet marks, under a valid/ready handshake. It leaves on an output stream of the same width.

On that output stream each beat is either a data word or a control slot. A control slot with a start flag comes before the first burst of every packet. A plain control slot separates two bursts of one packet. A control slot with an end flag follows the last burst. A burst ends at end-of-packet, or when it reaches the largest whole number of burst units that fits inside the programmed maximum burst size. The last data word of every burst is marked, so that neighbouring logic, such as a training-pattern inserter, can pause at a clean point.

The data path is combinational and has no storage. While a control slot is offered, the input is held back (`in_ready` low). The block keeps only its slot state and two word counters.

Top module: `burst_segmenter`

## Requirements
- R1: When `in_valid` rises while no packet is open, the block first offers a control slot with `out_ctrl`=1 and `out_ctl_sop`=1. While any control slot is offered, `in_ready` stays 0.
- R2: Each accepted data beat appears on the output in the same cycle. `out_data`, `out_sop` and `out_eop` equal `in_data`, `in_sop` and `in_eop`, and `out_ctrl`=0. On a control slot `out_data`, `out_sop` and `out_eop` are 0.
- R3: Bursts are counted in whole words. Let U be the burst unit and X the maximum burst size, both in words. Without end-of-packet, a burst closes after floor(X/U)·U words. The next beat is a control slot with `out_ctl_sop`=0 and `out_ctl_eop`=0.
- R4: When the maximum burst size is smaller than one unit, a burst without end-of-packet closes after exactly one unit.
- R5: U is `cfg_unit_bytes[9:log2(WORD_BYTES)]`, and the value 0 stands for 1024 bytes. X is `cfg_max_bytes[10:log2(WORD_BYTES)]`. The byte bits below the word size are ignored.
- R6: An end-of-packet word closes its burst at once, whatever the count. The next beat is a control slot with `out_ctl_eop`=1, and the next packet starts its counts from zero.
- R7: `out_burst_end` is 1 on exactly the data beats that close a burst (R3, R4, R6) and 0 on every other beat.
- R8: While `out_ready` is 0, no data is accepted, and an offered middle or end control slot stays offered unchanged. The burst count is not advanced by stalled cycles.
- R9: After reset, with `in_valid` low, `out_valid` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_unit_bytes | input | 10 | Burst unit size in bytes (0 means 1024) |
| cfg_max_bytes | input | 11 | Maximum burst size in bytes |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | 8*WORD_BYTES | Input word |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 8*WORD_BYTES | Output word (0 on control slots) |
| out_sop | output | 1 | Data beat starts a packet |
| out_eop | output | 1 | Data beat ends a packet |
| out_ctrl | output | 1 | Beat is a control slot |
| out_ctl_sop | output | 1 | Control slot opens a packet |
| out_ctl_eop | output | 1 | Control slot closes a packet |
| out_burst_end | output | 1 | Data beat is the last of its burst |

## Verification
A wrong word count or unit position shows up at once as a misplaced burst end. The mark appears one word early or late, and the control slot lands in the wrong beat of the stream. It is visible within one burst length of the fault. A wrong slot state shows up within a cycle, as a control slot missing or doubled, a wrong start/end flag, or `in_ready` high during a control slot. The scoreboard orders every output beat against a model of these rules, so any such slip breaks the sequence at the first affected beat.

// File: rtl/bseg_pkg.sv
// Shared types for the burst segmenter.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package bseg_pkg;

    // Output slot state: waiting for a packet, passing data,
    // or offering a middle or closing control slot.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_MIDCTL = 2'd2,
        ST_EOPCTL = 2'd3
    } seg_state_t;

endpackage

// File: rtl/bseg_limits.sv
// Converts the byte-valued unit and maximum settings into word counts.
// Assumes: WORD_BYTES is a power of two; byte bits below one word are ignored.
module bseg_limits #(
    parameter int WORD_BYTES = 16,
    localparam int LG = $clog2(WORD_BYTES),
    localparam int UW = 11 - LG
) (
    input  logic [9:0]    cfg_unit_bytes,
    input  logic [10:0]   cfg_max_bytes,
    output logic [UW-1:0] unit_w,
    output logic [UW-1:0] max_w
);
    localparam logic [UW-1:0] FULL_UNIT = UW'(1024 / WORD_BYTES);

    logic [9-LG:0] unit_field;

    // Unit in words; a zero field encodes the largest unit.
    always_comb begin
        unit_field = cfg_unit_bytes[9:LG];
        unit_w     = (unit_field == '0) ? FULL_UNIT : {1'b0, unit_field};
        max_w      = cfg_max_bytes[10:LG];
    end
endmodule

// File: rtl/bseg_counter.sv
// Tracks words in the open burst and the position inside the current unit,
// and flags the word that would close the burst on the size limit.
// Assumes: word_acc and clear never rise together.
module bseg_counter #(
    parameter int WORD_BYTES = 16,
    localparam int LG = $clog2(WORD_BYTES),
    localparam int UW = 11 - LG,
    localparam int CW = UW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_acc,
    input  logic          clear,
    input  logic [UW-1:0] unit_w,
    input  logic [UW-1:0] max_w,
    output logic          close_lim
);
    logic [CW-1:0] burst_w, nb;
    logic [UW-1:0] unit_pos, nu;
    logic [CW:0]   reach;
    logic          unit_end;

    // A burst closes at a unit boundary when one more unit would not fit.
    always_comb begin
        nu        = unit_pos + UW'(1);
        nb        = burst_w + CW'(1);
        unit_end  = (nu == unit_w);
        reach     = {1'b0, nb} + {2'b00, unit_w};
        close_lim = unit_end && (reach > {2'b00, max_w});
    end

    // Advance on each accepted word; restart after a control slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            burst_w  <= '0;
            unit_pos <= '0;
        end else if (word_acc) begin
            burst_w  <= nb;
            unit_pos <= unit_end ? '0 : nu;
        end
    end
endmodule

// File: rtl/bseg_fsm.sv
// Decides whether the output offers data or a control slot, and moves
// between packet, burst and idle phases.
// Assumes: close_lim is valid in the cycle a data word is offered.
module bseg_fsm
    import bseg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_eop,
    input  logic       out_ready,
    input  logic       close_lim,
    output seg_state_t state,
    output logic       ctl_valid,
    output logic       ctl_acc,
    output logic       word_acc
);
    seg_state_t nxt;

    // Handshake decode for control slots and data words.
    always_comb begin
        unique case (state)
            ST_IDLE:   ctl_valid = in_valid;
            ST_DATA:   ctl_valid = 1'b0;
            default:   ctl_valid = 1'b1;
        endcase
        ctl_acc  = ctl_valid && out_ready;
        word_acc = (state == ST_DATA) && in_valid && out_ready;
    end

    // Next slot state.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (ctl_acc) nxt = ST_DATA;
            ST_DATA:   if (word_acc) begin
                           if (in_eop)         nxt = ST_EOPCTL;
                           else if (close_lim) nxt = ST_MIDCTL;
                       end
            ST_MIDCTL: if (ctl_acc) nxt = ST_DATA;
            ST_EOPCTL: if (ctl_acc) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/burst_segmenter.sv
// Top of the burst segmenter: cuts one channel's packet stream into bursts
// bounded by unit and maximum sizes and opens control slots between them.
// Assumes: settings change only while no packet is open.
module burst_segmenter
    import bseg_pkg::*;
#(
    parameter int WORD_BYTES = 16,
    localparam int DW = 8 * WORD_BYTES,
    localparam int UW = 11 - $clog2(WORD_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [9:0]    cfg_unit_bytes,
    input  logic [10:0]   cfg_max_bytes,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    output logic          out_ctrl,
    output logic          out_ctl_sop,
    output logic          out_ctl_eop,
    output logic          out_burst_end
);
    seg_state_t    state;
    logic [UW-1:0] unit_w, max_w;
    logic          close_lim, ctl_valid, ctl_acc, word_acc, in_data_ph;

    bseg_limits #(.WORD_BYTES(WORD_BYTES)) u_limits (
        .cfg_unit_bytes(cfg_unit_bytes),
        .cfg_max_bytes (cfg_max_bytes),
        .unit_w        (unit_w),
        .max_w         (max_w)
    );

    bseg_counter #(.WORD_BYTES(WORD_BYTES)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_acc (word_acc),
        .clear    (ctl_acc),
        .unit_w   (unit_w),
        .max_w    (max_w),
        .close_lim(close_lim)
    );

    bseg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_eop   (in_eop),
        .out_ready(out_ready),
        .close_lim(close_lim),
        .state    (state),
        .ctl_valid(ctl_valid),
        .ctl_acc  (ctl_acc),
        .word_acc (word_acc)
    );

    // Output mux: data passes straight through; control slots carry flags only.
    always_comb begin
        in_data_ph    = (state == ST_DATA);
        in_ready      = in_data_ph && out_ready;
        out_valid     = in_data_ph ? in_valid : ctl_valid;
        out_ctrl      = !in_data_ph;
        out_ctl_sop   = (state == ST_IDLE);
        out_ctl_eop   = (state == ST_EOPCTL);
        out_data      = in_data_ph ? in_data : '0;
        out_sop       = in_data_ph && in_sop;
        out_eop       = in_data_ph && in_eop;
        out_burst_end = in_data_ph && in_valid && (in_eop || close_lim);
    end
endmodule

// File: rtl/bseg_checker.sv
// Port-level properties of the burst segmenter, bound to every instance.
// Assumes: settings stay constant while a packet is open.
module bseg_checker #(
    parameter int WORD_BYTES = 16,
    localparam int LG = $clog2(WORD_BYTES),
    localparam int UW = 11 - LG
) (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  cfg_unit_bytes,
    input logic [10:0] cfg_max_bytes,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_eop,
    input logic        out_ctrl,
    input logic        out_ctl_sop,
    input logic        out_ctl_eop,
    input logic        out_burst_end
);
    logic [UW-1:0] u_chk, x_chk, lim_chk;
    logic [UW:0]   beats;

    // Upper bound on words per burst derived from the settings.
    always_comb begin
        u_chk   = (cfg_unit_bytes[9:LG] == '0) ? UW'(1024 / WORD_BYTES)
                                               : {1'b0, cfg_unit_bytes[9:LG]};
        x_chk   = cfg_max_bytes[10:LG];
        lim_chk = (x_chk >= u_chk) ? x_chk : u_chk;
    end

    // Count data beats taken since the last control slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beats <= '0;
        else if (out_valid && out_ready)
            beats <= out_ctrl ? '0 : beats + 1'b1;
    end

    AST_CTL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl) |-> !in_ready); // R1
    AST_READY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready); // R8
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl && !out_ctl_sop && !out_ready)
        |=> (out_valid && out_ctrl && !out_ctl_sop && $stable(out_ctl_eop))); // R8
    AST_EOP_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_ctrl && out_eop)
        |=> (out_valid && out_ctrl && out_ctl_eop)); // R6
    AST_BEND_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_ctrl && out_burst_end)
        |=> (out_valid && out_ctrl && !out_ctl_sop)); // R7
    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_ctrl) |-> (beats < {1'b0, lim_chk})); // R3
endmodule

bind burst_segmenter bseg_checker #(.WORD_BYTES(WORD_BYTES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_unit_bytes(cfg_unit_bytes),
    .cfg_max_bytes(cfg_max_bytes),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_eop      (out_eop),
    .out_ctrl     (out_ctrl),
    .out_ctl_sop  (out_ctl_sop),
    .out_ctl_eop  (out_ctl_eop),
    .out_burst_end(out_burst_end)
);

// File: tb/burst_segmenter_tb_top.sv
// Scoreboard bench: the driver queues expected beats, the monitor compares.
module burst_segmenter_tb_top;
    localparam int WB = 16;
    localparam int DW = 8 * WB;
    localparam int IW = DW + 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    cfg_unit_bytes = 10'd64;
    logic [10:0]   cfg_max_bytes = 11'd256;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid, out_sop, out_eop;
    logic          out_ctrl, out_ctl_sop, out_ctl_eop, out_burst_end;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;

    int checks = 0, errors = 0, ready_mode = 0, cyc = 0;
    logic [15:0] seq = 16'h0;
    logic [IW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    burst_segmenter #(.WORD_BYTES(WB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_unit_bytes(cfg_unit_bytes), .cfg_max_bytes(cfg_max_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_ctrl(out_ctrl),
        .out_ctl_sop(out_ctl_sop), .out_ctl_eop(out_ctl_eop),
        .out_burst_end(out_burst_end)
    );

    task automatic check(input bit ok, input string req, input logic [IW-1:0] act,
                         input logic [IW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Downstream ready pattern, changed just after each edge.
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // Monitor: compare every transferred beat with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_ctrl && !out_ready)
                check(!in_ready, "R8 input held during stalled control",
                      IW'(in_ready), IW'(0));
            if (out_ready) begin
                logic [IW-1:0] act;
                act = {out_ctrl, out_ctl_sop, out_ctl_eop, out_burst_end,
                       out_sop, out_eop, out_data};
                if (exp_q.size() == 0)
                    check(1'b0, "R2 unexpected beat", act, '0);
                else begin
                    logic [IW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(act == e, t, act, e);
                end
            end
        end
    end

    function automatic logic [IW-1:0] ctl_item(input bit s, input bit e);
        return {1'b1, s, e, 3'b000, {DW{1'b0}}};
    endfunction

    // Driver: one packet of n words; the model follows R3-R7.
    task automatic send_packet(input int n);
        int u, x, eff, cnt;
        u   = (cfg_unit_bytes / WB) * WB;
        if (u == 0) u = 1024;                       // R5 zero means 1024
        x   = (cfg_max_bytes / WB) * WB;
        eff = (x / u) * u;                          // R3 round down
        if (eff == 0) eff = u;                      // R4 at least one unit
        cnt = 0;
        exp_q.push_back(ctl_item(1'b1, 1'b0)); tag_q.push_back("R1 opening control");
        for (int i = 0; i < n; i++) begin
            bit eop, bend;
            logic [DW-1:0] d;
            seq++;
            d   = {8{seq}};
            eop = (i == n - 1);
            cnt += WB;
            bend = eop || (cnt == eff);
            exp_q.push_back({1'b0, 2'b00, bend, (i == 0), eop, d});
            tag_q.push_back("R2 R7 data beat");
            if (eop) begin
                exp_q.push_back(ctl_item(1'b0, 1'b1)); tag_q.push_back("R6 closing control");
            end else if (bend) begin
                exp_q.push_back(ctl_item(1'b0, 1'b0)); tag_q.push_back("R3 R4 middle control");
                cnt = 0;
            end
            in_valid = 1'b1; in_data = d; in_sop = (i == 0); in_eop = eop;
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !in_ready, "R9 reset idle",
              IW'({out_valid, in_ready}), '0);
        // R3: unit 4 words, max 16 words, 40-word packet
        send_packet(40); drain();
        // R3 with non-multiple maximum under stalls (R8)
        ready_mode = 1;
        cfg_unit_bytes = 10'd48; cfg_max_bytes = 11'd200;
        send_packet(13); drain();
        // R4: maximum below one unit
        cfg_unit_bytes = 10'd128; cfg_max_bytes = 11'd64;
        send_packet(10); drain();
        // R5: zero unit field, low byte bits ignored
        ready_mode = 0;
        cfg_unit_bytes = 10'd0; cfg_max_bytes = 11'd2047;
        send_packet(70); drain();
        // R6: single-word packet, then end exactly at the limit
        cfg_unit_bytes = 10'd16; cfg_max_bytes = 11'd32;
        send_packet(1); drain();
        ready_mode = 1;
        send_packet(4); drain();
        send_packet(3); drain();
        check(exp_q.size() == 0, "R2 queue empty", IW'(exp_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2 watchdog expired", '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule